// File: doc/BRIEF.md
# Dual-Bank Affine Color Matrix

This block transforms each incoming RGB pixel with a 3x4 affine matrix. Every output channel is the weighted sum of the three input channels plus a constant offset. The result is rounded and then clamped to the unsigned pixel range. Two complete coefficient banks are held in configuration registers. Software loads the bank that is not in use and writes a new mode. At the next frame-start pulse that mode becomes the active one, so the new matrix takes effect on a frame boundary and never part-way through a frame.

Coefficients are signed fixed-point words with 2 integer bits and 13 fractional bits (16 bits in total). The offset column is a signed integer in pixel units. Converting floating-point values to these codes is the host's job. Pixels flow through a three-stage pipeline, and a valid flag travels with the data.

Top module: `cmx_top`

## Requirements
- R1: While reset is held, and right after it, out_valid is 0, mode_cur is 0, and every configuration register reads back 0.
- R2: Coefficient index k (row-major: k = 4*row + col, with col 3 holding the row's offset) is stored at register BASE + k/2. An even k sits in bits [15:0] and an odd k in bits [31:16]. Bank A uses BASE = 1 (addresses 1..6) and bank B uses BASE = 9 (addresses 9..14). Each of these registers reads back exactly what was written.
- R3: Bits [1:0] of register 0 hold the programmed mode, and reading register 0 returns it there. The active mode reads back in bits [9:8] and on mode_cur. The active mode takes the programmed value on the clock edge where frame_start is high, and at no other edge. A mode write in that same cycle takes effect at the following frame start.
- R4: When the active mode is 0 or 3, each output channel equals its input channel, whatever the coefficients are.
- R5: With active mode 1, output channel i = clamp(floor((c_i0*R + c_i1*G + c_i2*B + 4096) / 8192) + c_i3) using bank A, where rows 0, 1 and 2 give R, G and B.
- R6: With active mode 2, the same formula applies using bank B only.
- R7: Rounding is half-up on the fractional product sum: a sum exactly halfway between two integers goes to the larger one, for negative sums as well.
- R8: Results below 0 become 0 and results above 2^PIX_W-1 (4095) become 4095. This holds for extreme coefficient values (-32768 and 32767).
- R9: A pixel sampled with in_valid at clock edge n appears at the outputs with out_valid high after edge n+2. Pixels may be accepted on every cycle. out_valid is never high without a matching input.
- R10: Writes to addresses outside register 0, 1..6 and 9..14 change nothing, and those addresses read back 0.
- R11: Rewriting the inactive bank while the other bank is active leaves the pixel results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | ADDR_W (4) | Write address |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | ADDR_W (4) | Read address |
| cfg_rdata | output | 32 | Read data, combinational from cfg_raddr |
| frame_start | input | 1 | Pulse that copies the programmed mode into the active mode |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | PIX_W (12) | Input red |
| in_g | input | PIX_W (12) | Input green |
| in_b | input | PIX_W (12) | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | PIX_W (12) | Output red |
| out_g | output | PIX_W (12) | Output green |
| out_b | output | PIX_W (12) | Output blue |
| mode_cur | output | 2 | Active mode |

## Verification
The bench sweeps a grid of channel values that includes 0, 1, 3, the midpoint pair and full scale. It runs this grid under every mode, including the alternate bypass code 3, and with matrices that mix signs, hit the coefficient extremes and force both clamps.

The grid targets the following mistakes:
- A truncating or round-to-even datapath gives wrong results for the odd inputs multiplied by 0.5 and -0.5.
- A wrap instead of a clamp shows up as small values where 4095 or 0 is expected.
- A design that switches mode on the write itself, rather than on the frame pulse, fails the check taken between the write and the pulse.
- Swapped pair halves or a wrong bank base show up both in readback and in the results.
- A latency off by one shows up in the cycle-exact valid check.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

  typedef enum logic [1:0] {
    MODE_PASS     = 2'd0,
    MODE_SET_A    = 2'd1,
    MODE_SET_B    = 2'd2,
    MODE_PASS_ALT = 2'd3
  } cmx_mode_e;

  localparam int unsigned NUM_ROWS  = 3;
  localparam int unsigned NUM_COLS  = 4;
  localparam int unsigned NUM_COEF  = NUM_ROWS * NUM_COLS;
  localparam int unsigned NUM_PAIRS = NUM_COEF / 2;
  localparam int unsigned NUM_BANKS = 2;

  function automatic logic mode_is_pass(input cmx_mode_e m);
    return (m == MODE_PASS) || (m == MODE_PASS_ALT);
  endfunction

endpackage

// File: rtl/cmx_cfg.sv
module cmx_cfg
  import cmx_pkg::*;
#(
  parameter int COEF_W    = 16,
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int BASE_A    = 1,
  parameter int BASE_B    = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          waddr,
  input  logic [31:0]                wdata,
  input  logic [ADDR_W-1:0]          raddr,
  output logic [31:0]                rdata,
  input  logic                       frame_start,
  output cmx_mode_e                  prog_mode,
  output cmx_mode_e                  cur_mode,
  output logic [NUM_COEF*COEF_W-1:0] bank_a,
  output logic [NUM_COEF*COEF_W-1:0] bank_b
);

  localparam int BANK_W = NUM_COEF * COEF_W;
  localparam int HI_LSB = 16;

  wire [BANK_W-1:0] bank_flat [NUM_BANKS];
  wire [31:0]       rd_word   [NUM_BANKS][NUM_PAIRS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BASE = (b == 0) ? BASE_A : BASE_B;
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      logic [COEF_W-1:0] lo_q, hi_q;
      logic              hit;
      assign hit = we && (waddr == ADDR_W'(BASE + p));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_q <= '0;
          hi_q <= '0;
        end else if (hit) begin
          lo_q <= wdata[COEF_W-1:0];
          hi_q <= wdata[HI_LSB +: COEF_W];
        end
      end
      assign bank_flat[b][(2*p)*COEF_W +: COEF_W]   = lo_q;
      assign bank_flat[b][(2*p+1)*COEF_W +: COEF_W] = hi_q;
      assign rd_word[b][p] = (32'(hi_q) << HI_LSB) | 32'(lo_q);
    end
  end

  assign bank_a = bank_flat[0];
  assign bank_b = bank_flat[1];

  cmx_mode_e prog_q, cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= MODE_PASS;
      cur_q  <= MODE_PASS;
    end else begin
      if (we && (waddr == ADDR_W'(CTRL_ADDR))) prog_q <= cmx_mode_e'(wdata[1:0]);
      if (frame_start) cur_q <= prog_q;
    end
  end

  assign prog_mode = prog_q;
  assign cur_mode  = cur_q;

  always_comb begin
    rdata = '0;
    if (raddr == ADDR_W'(CTRL_ADDR)) rdata = {22'd0, cur_q, 6'd0, prog_q};
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if (raddr == ADDR_W'(((b == 0) ? BASE_A : BASE_B) + p)) rdata = rd_word[b][p];
      end
    end
  end

endmodule

// File: rtl/cmx_row.sv
module cmx_row #(
  parameter int PIX_W  = 12,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PIX_W-1:0]    pix_r,
  input  logic [PIX_W-1:0]    pix_g,
  input  logic [PIX_W-1:0]    pix_b,
  input  logic [4*COEF_W-1:0] coef_row,
  input  logic                pass_i,
  input  logic [PIX_W-1:0]    pass_pix_i,
  output logic [PIX_W-1:0]    out_o
);

  localparam int PROD_W = COEF_W + PIX_W + 1;
  localparam int ACC_W  = PROD_W + 2;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << PIX_W) - 1);

  function automatic logic signed [PROD_W-1:0] mul_term(
    input logic [COEF_W-1:0] c,
    input logic [PIX_W-1:0]  p
  );
    logic signed [PROD_W-1:0] cs, ps;
    cs = $signed({{(PROD_W-COEF_W){c[COEF_W-1]}}, c});
    ps = $signed({{(PROD_W-PIX_W){1'b0}}, p});
    return cs * ps;
  endfunction

  function automatic logic signed [ACC_W-1:0] widen(input logic signed [PROD_W-1:0] v);
    return $signed({{(ACC_W-PROD_W){v[PROD_W-1]}}, v});
  endfunction

  function automatic logic [PIX_W-1:0] round_sat(
    input logic signed [ACC_W-1:0] acc,
    input logic [COEF_W-1:0]       off
  );
    logic signed [ACC_W-1:0] t;
    logic signed [ACC_W-1:0] o;
    o = $signed({{(ACC_W-COEF_W){off[COEF_W-1]}}, off});
    t = (acc + HALF) >>> FRAC_W;
    t = t + o;
    if (t < 0)         return '0;
    else if (t > MAXV) return {PIX_W{1'b1}};
    else               return t[PIX_W-1:0];
  endfunction

  logic signed [PROD_W-1:0] prod_q [3];
  logic [COEF_W-1:0]        off_q;
  logic                     pass_q;
  logic [PIX_W-1:0]         pass_pix_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < 3; j++) prod_q[j] <= '0;
      off_q      <= '0;
      pass_q     <= 1'b1;
      pass_pix_q <= '0;
    end else begin
      prod_q[0]  <= mul_term(coef_row[0*COEF_W +: COEF_W], pix_r);
      prod_q[1]  <= mul_term(coef_row[1*COEF_W +: COEF_W], pix_g);
      prod_q[2]  <= mul_term(coef_row[2*COEF_W +: COEF_W], pix_b);
      off_q      <= coef_row[3*COEF_W +: COEF_W];
      pass_q     <= pass_i;
      pass_pix_q <= pass_pix_i;
    end
  end

  logic signed [ACC_W-1:0] sum_w;
  assign sum_w = widen(prod_q[0]) + widen(prod_q[1]) + widen(prod_q[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_o <= '0;
    else if (pass_q) out_o <= pass_pix_q;
    else             out_o <= round_sat(sum_w, off_q);
  end

endmodule

// File: rtl/cmx_top.sv
module cmx_top
  import cmx_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 13,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_waddr,
  input  logic [31:0]       cfg_wdata,
  input  logic [ADDR_W-1:0] cfg_raddr,
  output logic [31:0]       cfg_rdata,
  input  logic              frame_start,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_r,
  input  logic [PIX_W-1:0]  in_g,
  input  logic [PIX_W-1:0]  in_b,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b,
  output logic [1:0]        mode_cur
);

  localparam int BANK_W = NUM_COEF * COEF_W;
  localparam int ROW_W  = NUM_COLS * COEF_W;

  cmx_mode_e         prog_mode_w, cur_mode_w;
  logic [BANK_W-1:0] bank_a_w, bank_b_w;

  cmx_cfg #(
    .COEF_W(COEF_W), .ADDR_W(ADDR_W), .CTRL_ADDR(0), .BASE_A(1), .BASE_B(9)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
    .raddr(cfg_raddr), .rdata(cfg_rdata), .frame_start(frame_start),
    .prog_mode(prog_mode_w), .cur_mode(cur_mode_w), .bank_a(bank_a_w), .bank_b(bank_b_w)
  );

  assign mode_cur = cur_mode_w;

  logic [PIX_W-1:0] s1_pix [NUM_ROWS];
  cmx_mode_e        s1_mode;
  logic             v1_q, v2_q, v3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ROWS; i++) s1_pix[i] <= '0;
      s1_mode <= MODE_PASS;
      v1_q    <= 1'b0;
      v2_q    <= 1'b0;
      v3_q    <= 1'b0;
    end else begin
      s1_pix[0] <= in_r;
      s1_pix[1] <= in_g;
      s1_pix[2] <= in_b;
      s1_mode   <= cur_mode_w;
      v1_q      <= in_valid;
      v2_q      <= v1_q;
      v3_q      <= v2_q;
    end
  end

  logic [BANK_W-1:0] sel_bank;
  logic              pass_w;
  assign sel_bank = (s1_mode == MODE_SET_B) ? bank_b_w : bank_a_w;
  assign pass_w   = mode_is_pass(s1_mode);

  logic [PIX_W-1:0] row_out [NUM_ROWS];

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    cmx_row #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_row (
      .clk(clk), .rst_n(rst_n),
      .pix_r(s1_pix[0]), .pix_g(s1_pix[1]), .pix_b(s1_pix[2]),
      .coef_row(sel_bank[i*ROW_W +: ROW_W]),
      .pass_i(pass_w), .pass_pix_i(s1_pix[i]),
      .out_o(row_out[i])
    );
  end

  assign out_valid = v3_q;
  assign out_r     = row_out[0];
  assign out_g     = row_out[1];
  assign out_b     = row_out[2];

endmodule

// File: rtl/cmx_checker.sv
module cmx_checker #(
  parameter int PIX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic [1:0]       prog_mode,
  input logic [1:0]       mode_cur,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_r,
  input logic [PIX_W-1:0] in_g,
  input logic [PIX_W-1:0] in_b,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_r,
  input logic [PIX_W-1:0] out_g,
  input logic [PIX_W-1:0] out_b
);

  logic [1:0] since_rst;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  assign warm = (since_rst == 2'd3);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_state: assert (!out_valid && mode_cur == 2'd0);
    end
  end

  a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 3)));

  a_r4_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 3) && ($past(mode_cur, 3) == 2'd0 || $past(mode_cur, 3) == 2'd3))
    |-> (out_r == $past(in_r, 3) && out_g == $past(in_g, 3) && out_b == $past(in_b, 3)));

  a_r3_flip_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (mode_cur == $past(prog_mode)));

  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mode_cur));

endmodule

bind cmx_top cmx_checker #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .prog_mode(prog_mode_w),
  .mode_cur(mode_cur), .in_valid(in_valid), .in_r(in_r), .in_g(in_g), .in_b(in_b),
  .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
);

// File: tb/tb_cmx_top.sv
module tb_cmx_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_waddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic        frame_start = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_r = '0, in_g = '0, in_b = '0;
  logic        out_valid;
  logic [11:0] out_r, out_g, out_b;
  logic [1:0]  mode_cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmx_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .frame_start(frame_start),
    .in_valid(in_valid), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b), .mode_cur(mode_cur)
  );

  int errors = 0;
  int checks = 0;
  int bank_m [2][12];
  int exp_mode = 0;
  string tag = "R4";
  logic [35:0] expq [$];

  int grid [9] = '{0, 1, 3, 100, 1000, 2047, 2048, 4000, 4095};

  task automatic check(string req, logic ok, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic longint floor_div(longint n);
    if (n >= 0) return n / 8192;
    return -((-n + 8191) / 8192);
  endfunction

  function automatic logic [11:0] model_ch(int row, int r, int g, int b, logic [11:0] pass);
    longint s, q;
    int k;
    if (exp_mode == 0 || exp_mode == 3) return pass;
    k = (exp_mode == 2) ? 1 : 0;
    s = longint'(bank_m[k][row*4]) * r + longint'(bank_m[k][row*4+1]) * g
      + longint'(bank_m[k][row*4+2]) * b;
    q = floor_div(s + 4096) + bank_m[k][row*4+3];
    if (q < 0) return 12'd0;
    if (q > 4095) return 12'd4095;
    return 12'(q);
  endfunction

  task automatic cfg_write(int addr, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = 4'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(int addr, output logic [31:0] data);
    @(negedge clk);
    cfg_raddr = 4'(addr);
    #1 data = cfg_rdata;
  endtask

  task automatic load_bank(int b);
    for (int p = 0; p < 6; p++)
      cfg_write((b == 0 ? 1 : 9) + p,
                {16'(bank_m[b][2*p+1]), 16'(bank_m[b][2*p])});
  endtask

  task automatic flip();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic send_px(int r, int g, int b);
    @(negedge clk);
    in_valid = 1'b1; in_r = 12'(r); in_g = 12'(g); in_b = 12'(b);
    expq.push_back({model_ch(0, r, g, b, 12'(r)), model_ch(1, r, g, b, 12'(g)),
                    model_ch(2, r, g, b, 12'(b))});
  endtask

  task automatic drain();
    @(negedge clk); in_valid = 1'b0;
    repeat (6) @(negedge clk);
    check({tag, " drain"}, expq.size() == 0, expq.size(), 0);
  endtask

  task automatic sweep();
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 9; j++)
        for (int k = 0; k < 9; k++)
          send_px(grid[i], grid[j], grid[(k + i) % 9]);
    drain();
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        check("R9 unexpected out_valid", 1'b0, 1, 0);
      end else begin
        logic [35:0] e;
        e = expq.pop_front();
        check(tag, {out_r, out_g, out_b} == e, {out_r, out_g, out_b}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 1'b0, 0, 1);
    finish_up();
  end

  initial begin
    logic [31:0] rd;
    // matrix A: mixed signs, drives both clamps
    bank_m[0] = '{6144, 1638, 410, 5,  -819, 9011, 0, -3,  2458, -3277, 9830, 0};
    // matrix B: half gain rounding, negation, extreme coefficients
    bank_m[1] = '{4096, 0, 0, 10,  0, -4096, 0, 2047,  32767, -32768, 0, 0};

    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1 out_valid", out_valid == 1'b0, out_valid, 0);
    check("R1 mode_cur", mode_cur == 2'd0, mode_cur, 0);
    rst_n = 1'b1;
    cfg_read(0, rd);  check("R1 ctrl", rd == 32'd0, rd, 0);
    cfg_read(1, rd);  check("R1 bankA", rd == 32'd0, rd, 0);
    cfg_read(14, rd); check("R1 bankB", rd == 32'd0, rd, 0);
    check("R1 mode_cur after", mode_cur == 2'd0, mode_cur, 0);

    // R2: load both banks and read back packing
    load_bank(0);
    load_bank(1);
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 6; p++) begin
        logic [31:0] ex;
        ex = {16'(bank_m[b][2*p+1]), 16'(bank_m[b][2*p])};
        cfg_read((b == 0 ? 1 : 9) + p, rd);
        check("R2 readback", rd == ex, rd, ex);
      end

    // R10: unmapped addresses
    cfg_write(7, 32'hDEAD_BEEF);
    cfg_write(8, 32'h1234_5678);
    cfg_write(15, 32'hFFFF_FFFF);
    cfg_read(7, rd);  check("R10 addr7", rd == 32'd0, rd, 0);
    cfg_read(8, rd);  check("R10 addr8", rd == 32'd0, rd, 0);
    cfg_read(15, rd); check("R10 addr15", rd == 32'd0, rd, 0);
    cfg_read(6, rd);
    check("R10 bankA intact", rd == {16'(bank_m[0][11]), 16'(bank_m[0][10])}, rd,
          {16'(bank_m[0][11]), 16'(bank_m[0][10])});

    // R3: program mode 1, not active until frame start
    cfg_write(0, 32'd1);
    cfg_read(0, rd); check("R3 pending ctrl", rd == 32'h0000_0001, rd, 32'h1);
    check("R3 no early flip", mode_cur == 2'd0, mode_cur, 0);

    // R4: bypass under mode 0 with nonzero coefficients
    tag = "R4 mode0"; exp_mode = 0;
    sweep();

    // R9: exact latency
    send_px(123, 456, 789);
    @(negedge clk); in_valid = 1'b0;
    check("R9 edge n", out_valid == 1'b0, out_valid, 0);
    @(negedge clk);
    check("R9 edge n+1", out_valid == 1'b0, out_valid, 0);
    @(negedge clk);
    check("R9 edge n+2", out_valid == 1'b1, out_valid, 1);
    drain();

    flip();
    check("R3 flip to A", mode_cur == 2'd1, mode_cur, 1);
    cfg_read(0, rd); check("R3 ctrl active", rd == 32'h0000_0101, rd, 32'h101);
    tag = "R5 R7 R8 set A"; exp_mode = 1;
    sweep();

    cfg_write(0, 32'd2);
    flip();
    check("R3 flip to B", mode_cur == 2'd2, mode_cur, 2);
    tag = "R6 R7 R8 set B"; exp_mode = 2;
    sweep();

    // R11: rewrite idle bank A while B active
    bank_m[0] = '{8192, 8192, 8192, 32767,  -8192, -8192, -8192, -32768,  0, 0, 8192, -2048};
    load_bank(0);
    tag = "R11 B after A rewrite";
    sweep();

    cfg_write(0, 32'd1);
    flip();
    tag = "R8 saturating A"; exp_mode = 1;
    sweep();

    // R4: alternate bypass code 3
    cfg_write(0, 32'd3);
    flip();
    check("R3 flip to 3", mode_cur == 2'd3, mode_cur, 3);
    tag = "R4 mode3"; exp_mode = 3;
    sweep();

    finish_up();
  end

endmodule